// File: doc/BRIEF.md
# Dual Wiper Register Command Executor

This block holds two 10-bit wiper codes and runs 24-bit commands against them. Each wiper has a saved copy that stands in for a nonvolatile setting. A small byte area for user data sits beside the two saved copies. The commands cover several kinds of change:

- loading a code directly;
- single steps up or down, with saturation at both ends;
- doubling and halving, which are the ±6 dB log-taper steps;
- saving a wiper to its copy and restoring it back;
- reading back a live code, a saved code or a user byte.

Slow nonvolatile operations and readbacks are modelled by a busy timer that holds the active-high ready output low for a parameterised number of clock cycles. While ready is low, every command is ignored and flagged. An active-low write-protect input blocks every command that would change state, apart from the restores. A rising edge on the preset input reloads both wipers from their saved copies. After reset the block restores from the store, and ready stays low for the refresh interval.

The command word is split into three fields. Bits 23:20 carry the opcode and bits 19:15 carry a 5-bit selector. Bits 9:0 carry the data, and bits 14:10 are unused. Selector 0 addresses wiper A and selector 1 addresses wiper B. Selectors 2 to 27 address user bytes 0 to 25.

Top module: `dual_wiper_exec`

## Requirements
- R1: While reset is held and right after it, both wipers and both saved copies read 512. After reset is released, rdy stays low for REFRESH_CYC clock cycles and then goes high.
- R2: Opcode 11 loads data[9:0] into the wiper that the selector names (0 = A, 1 = B). rd_data, rdy and the other wiper do not change.
- R3: Opcode 14 steps the selected wiper up by one and opcode 15 steps both wipers up. Opcode 6 steps the selected wiper down by one and opcode 7 steps both down. Up-steps stop at 1023 and down-steps stop at 0.
- R4: Opcode 12 doubles the selected wiper and opcode 13 doubles both. A code of 512 or more doubles to 1023. Opcode 4 halves the selected wiper and opcode 5 halves both, dropping the remainder, so 1 and 0 give 0.
- R5: Opcode 2 copies the selected wiper into its saved copy. Opcode 1 reloads the selected wiper from its saved copy. Opcode 8 reloads both wipers.
- R6: An accepted command starts a busy interval in the cycle after acceptance. Opcodes 2 and 3 hold rdy low for STORE_CYC cycles, opcode 8 for REFRESH_CYC cycles, and opcodes 9 and 10 for READ_CYC cycles. All other opcodes leave rdy high.
- R7: A command presented while rdy is low changes nothing, and cmd_err is high in the next cycle.
- R8: Opcode 10 reads the selected wiper. Opcode 9 reads a saved copy (selector 0 or 1) or user byte selector−2 (selector 2 to 27), zero-extended. The value appears on rd_data, and rd_valid pulses for one cycle in the cycle that rdy returns high.
- R9: Opcode 3 writes data[7:0] into user byte selector−2 when the selector is between 2 and 27. Any other selector rejects the command and raises cmd_err.
- R10: While wp_n is low, opcodes 2 to 7 and 11 to 15 are rejected with cmd_err and change nothing. Opcodes 0, 1, 8, 9 and 10 still run.
- R11: A rising edge on preset reloads both wipers from their saved copies and holds rdy low for REFRESH_CYC cycles. Keeping preset high afterwards has no further effect.
- R12: An opcode that acts on one wiper (1, 2, 4, 6, 10, 11, 12, 14) with a selector above 1 is rejected with cmd_err and leaves both wipers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 24 | Opcode, selector and data |
| wp_n | input | 1 | Write protect, active low |
| preset | input | 1 | Reload both wipers on a rising edge |
| rdy | output | 1 | High when idle; low during a busy interval |
| wiper_a | output | 10 | Code of wiper A |
| wiper_b | output | 10 | Code of wiper B |
| rd_valid | output | 1 | One-cycle pulse that marks readback data |
| rd_data | output | 10 | Readback value |
| cmd_err | output | 1 | Pulse for an ignored or rejected command |

## Verification
The bench builds the block with STORE_CYC=20, REFRESH_CYC=8 and READ_CYC=4, instead of the millisecond-scale defaults. With these values every busy interval ends within a few dozen cycles. This lets the bench count the exact cycle at which rdy rises after reset, after a store, after a refresh, after a readback and after a preset edge. It also lets the bench send a command in the middle of a store interval and see it rejected.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

  localparam logic [3:0] OP_NOP         = 4'd0;
  localparam logic [3:0] OP_RESTORE_ONE = 4'd1;
  localparam logic [3:0] OP_SAVE_ONE    = 4'd2;
  localparam logic [3:0] OP_USER_WR     = 4'd3;
  localparam logic [3:0] OP_SHR_ONE     = 4'd4;
  localparam logic [3:0] OP_SHR_BOTH    = 4'd5;
  localparam logic [3:0] OP_DEC_ONE     = 4'd6;
  localparam logic [3:0] OP_DEC_BOTH    = 4'd7;
  localparam logic [3:0] OP_RESTORE_ALL = 4'd8;
  localparam logic [3:0] OP_READ_SAVED  = 4'd9;
  localparam logic [3:0] OP_READ_WIPER  = 4'd10;
  localparam logic [3:0] OP_LOAD_ONE    = 4'd11;
  localparam logic [3:0] OP_SHL_ONE     = 4'd12;
  localparam logic [3:0] OP_SHL_BOTH    = 4'd13;
  localparam logic [3:0] OP_INC_ONE     = 4'd14;
  localparam logic [3:0] OP_INC_BOTH    = 4'd15;

  typedef enum logic [2:0] {
    WK_HOLD, WK_LOAD, WK_RESTORE, WK_INC, WK_DEC, WK_SHL, WK_SHR
  } wk_e;

  typedef enum logic [1:0] {BZ_NONE, BZ_STORE, BZ_REFRESH, BZ_READ} bz_e;

  typedef enum logic [1:0] {RS_NONE, RS_WIPER, RS_SAVED, RS_USER} rs_e;

  typedef struct packed {
    logic            reject;
    wk_e [1:0]       kind;
    logic [1:0]      save;
    logic            user_we;
    bz_e             busy;
    rs_e             rsrc;
  } dec_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import dwx_pkg::*;
#(
  parameter int SEL_W      = 5,
  parameter int USER_BYTES = 26
) (
  input  logic [3:0]       op,
  input  logic [SEL_W-1:0] sel,
  input  logic             wp_n,
  output dec_t             dec
);

  logic single_ok, user_ok;
  logic one, prot, bad, save_one;
  wk_e  kone, kall;

  assign single_ok = int'(sel) < 2;
  assign user_ok   = (int'(sel) >= 2) && (int'(sel) < 2 + USER_BYTES);

  always_comb begin
    dec      = '0;
    kone     = WK_HOLD;
    kall     = WK_HOLD;
    one      = 1'b0;
    prot     = 1'b0;
    bad      = 1'b0;
    save_one = 1'b0;
    case (op)
      OP_RESTORE_ONE: begin one = 1'b1; kone = WK_RESTORE; end
      OP_SAVE_ONE:    begin one = 1'b1; prot = 1'b1; save_one = 1'b1; dec.busy = BZ_STORE; end
      OP_USER_WR:     begin prot = 1'b1; dec.user_we = 1'b1; dec.busy = BZ_STORE; bad = !user_ok; end
      OP_SHR_ONE:     begin one = 1'b1; prot = 1'b1; kone = WK_SHR; end
      OP_SHR_BOTH:    begin prot = 1'b1; kall = WK_SHR; end
      OP_DEC_ONE:     begin one = 1'b1; prot = 1'b1; kone = WK_DEC; end
      OP_DEC_BOTH:    begin prot = 1'b1; kall = WK_DEC; end
      OP_RESTORE_ALL: begin kall = WK_RESTORE; dec.busy = BZ_REFRESH; end
      OP_READ_SAVED: begin
        dec.busy = BZ_READ;
        if (single_ok)    dec.rsrc = RS_SAVED;
        else if (user_ok) dec.rsrc = RS_USER;
        else              bad = 1'b1;
      end
      OP_READ_WIPER:  begin one = 1'b1; dec.busy = BZ_READ; dec.rsrc = RS_WIPER; end
      OP_LOAD_ONE:    begin one = 1'b1; prot = 1'b1; kone = WK_LOAD; end
      OP_SHL_ONE:     begin one = 1'b1; prot = 1'b1; kone = WK_SHL; end
      OP_SHL_BOTH:    begin prot = 1'b1; kall = WK_SHL; end
      OP_INC_ONE:     begin one = 1'b1; prot = 1'b1; kone = WK_INC; end
      OP_INC_BOTH:    begin prot = 1'b1; kall = WK_INC; end
      default: ;
    endcase
    if (one && !single_ok) bad = 1'b1;
    for (int i = 0; i < 2; i++) begin
      dec.kind[i] = (one && sel[0] == i[0]) ? kone : kall;
      dec.save[i] = save_one && (sel[0] == i[0]);
    end
    if (bad || (prot && !wp_n)) begin
      dec        = '0;
      dec.reject = 1'b1;
    end
  end

endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
  import dwx_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  wk_e          kind,
  input  logic [W-1:0] data,
  input  logic         save,
  output logic [W-1:0] code,
  output logic [W-1:0] saved_code
);

  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] code_q, sav_q, nxt;

  always_comb begin
    case (kind)
      WK_LOAD:    nxt = data;
      WK_RESTORE: nxt = sav_q;
      WK_INC:     nxt = (code_q == TOP) ? TOP : code_q + W'(1);
      WK_DEC:     nxt = (code_q == '0) ? '0 : code_q - W'(1);
      WK_SHL:     nxt = code_q[W-1] ? TOP : {code_q[W-2:0], 1'b0};
      WK_SHR:     nxt = {1'b0, code_q[W-1:1]};
      default:    nxt = code_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= MID;
      sav_q  <= MID;
    end else begin
      code_q <= nxt;
      if (save) sav_q <= code_q;
    end
  end

  assign code       = code_q;
  assign saved_code = sav_q;

  AST_SHL_SAT: assert property (@(posedge clk) disable iff (rst)
    (kind == WK_SHL && code_q[W-1]) |=> (code_q == TOP)); // R4
  AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (kind == WK_DEC && code_q == '0) |=> (code_q == '0)); // R3

endmodule

// File: rtl/busy_timer.sv
module busy_timer
  import dwx_pkg::*;
#(
  parameter int STORE_CYC   = 4_000_000,
  parameter int REFRESH_CYC = 200_000,
  parameter int READ_CYC    = 20_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  bz_e  kind,
  output logic busy,
  output logic fin
);

  localparam int MAXC  = (STORE_CYC > REFRESH_CYC) ?
                         ((STORE_CYC > READ_CYC) ? STORE_CYC : READ_CYC) :
                         ((REFRESH_CYC > READ_CYC) ? REFRESH_CYC : READ_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt, load;
  logic             busy_q;

  always_comb begin
    case (kind)
      BZ_STORE:   load = CNT_W'(STORE_CYC - 1);
      BZ_REFRESH: load = CNT_W'(REFRESH_CYC - 1);
      BZ_READ:    load = CNT_W'(READ_CYC - 1);
      default:    load = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b1;
      cnt    <= CNT_W'(REFRESH_CYC - 1);
    end else if (start) begin
      busy_q <= 1'b1;
      cnt    <= load;
    end else if (busy_q) begin
      if (cnt == '0) busy_q <= 1'b0;
      else           cnt    <= cnt - CNT_W'(1);
    end
  end

  assign busy = busy_q;
  assign fin  = busy_q && (cnt == '0);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && kind != BZ_NONE) |=> busy); // R6

endmodule

// File: rtl/dual_wiper_exec.sv
module dual_wiper_exec
  import dwx_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int SEL_W       = 5,
  parameter int CMD_W       = 24,
  parameter int USER_BYTES  = 26,
  parameter int STORE_CYC   = 4_000_000,
  parameter int REFRESH_CYC = 200_000,
  parameter int READ_CYC    = 20_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              wp_n,
  input  logic              preset,
  output logic              rdy,
  output logic [CODE_W-1:0] wiper_a,
  output logic [CODE_W-1:0] wiper_b,
  output logic              rd_valid,
  output logic [CODE_W-1:0] rd_data,
  output logic              cmd_err
);

  localparam int UIDX_W = $clog2(USER_BYTES);

  logic [3:0]        op;
  logic [SEL_W-1:0]  sel, uoff;
  logic [CODE_W-1:0] data;
  logic [UIDX_W-1:0] uidx;
  dec_t              dec;
  logic              busy, fin, preset_q, preset_rise, accept, reject_now, rd_pend;
  logic [CODE_W-1:0] wip [2];
  logic [CODE_W-1:0] sav [2];
  logic [7:0]        umem [USER_BYTES];

  assign op   = cmd_word[CMD_W-1 -: 4];
  assign sel  = cmd_word[CMD_W-5 -: SEL_W];
  assign data = cmd_word[CODE_W-1:0];
  assign uoff = sel - SEL_W'(2);
  assign uidx = uoff[UIDX_W-1:0];

  cmd_decode #(.SEL_W(SEL_W), .USER_BYTES(USER_BYTES)) u_dec (
    .op(op), .sel(sel), .wp_n(wp_n), .dec(dec)
  );

  assign preset_rise = preset && !preset_q;
  assign accept      = cmd_valid && !busy && !preset_rise && !dec.reject;
  assign reject_now  = cmd_valid && (busy || preset_rise || dec.reject);

  busy_timer #(.STORE_CYC(STORE_CYC), .REFRESH_CYC(REFRESH_CYC), .READ_CYC(READ_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .start(preset_rise || (accept && dec.busy != BZ_NONE)),
    .kind(preset_rise ? BZ_REFRESH : dec.busy),
    .busy(busy), .fin(fin)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ch
    wk_e kind_g;
    always_comb begin
      if (preset_rise)  kind_g = WK_RESTORE;
      else if (accept)  kind_g = dec.kind[g];
      else              kind_g = WK_HOLD;
    end
    wiper_channel #(.W(CODE_W)) u_ch (
      .clk(clk), .rst(rst), .kind(kind_g), .data(data),
      .save(accept && dec.save[g]),
      .code(wip[g]), .saved_code(sav[g])
    );
  end

  always_ff @(posedge clk) begin
    if (accept && dec.user_we) umem[uidx] <= data[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q <= 1'b1;
      cmd_err  <= 1'b0;
      rd_valid <= 1'b0;
      rd_pend  <= 1'b0;
      rd_data  <= '0;
    end else begin
      preset_q <= preset;
      cmd_err  <= reject_now;
      rd_valid <= 1'b0;
      if (preset_rise) begin
        rd_pend <= 1'b0;
      end else if (accept && dec.rsrc != RS_NONE) begin
        rd_pend <= 1'b1;
        case (dec.rsrc)
          RS_WIPER: rd_data <= wip[sel[0]];
          RS_SAVED: rd_data <= sav[sel[0]];
          default:  rd_data <= CODE_W'(umem[uidx]);
        endcase
      end else if (fin && rd_pend) begin
        rd_valid <= 1'b1;
        rd_pend  <= 1'b0;
      end
    end
  end

  assign rdy     = !busy;
  assign wiper_a = wip[0];
  assign wiper_b = wip[1];

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!rdy && !preset_rise) |=> ($stable(wiper_a) && $stable(wiper_b))); // R7
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !rdy) |=> cmd_err); // R7
  AST_WP_GUARD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rdy && !wp_n && !preset_rise && op != OP_RESTORE_ONE && op != OP_RESTORE_ALL)
    |=> ($stable(wiper_a) && $stable(wiper_b))); // R10
  AST_INC_CEIL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rdy && wp_n && !preset_rise && op == OP_INC_BOTH && wiper_a == {CODE_W{1'b1}})
    |=> (wiper_a == {CODE_W{1'b1}})); // R3
  AST_SHR_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rdy && wp_n && !preset_rise && op == OP_SHR_BOTH && wiper_b <= CODE_W'(1))
    |=> (wiper_b == '0)); // R4
  AST_RD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(rdy)); // R8
  AST_PRESET_BUSY: assert property (@(posedge clk) disable iff (rst)
    preset_rise |=> !rdy); // R11

endmodule

// File: tb/dual_wiper_exec_test.sv
`timescale 1ns/1ps
module dual_wiper_exec_test;

  localparam int ST = 20;
  localparam int RF = 8;
  localparam int RD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic        wp_n = 1'b1;
  logic        preset = 1'b0;
  logic        rdy, rd_valid, cmd_err;
  logic [9:0]  wiper_a, wiper_b, rd_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_wiper_exec #(.STORE_CYC(ST), .REFRESH_CYC(RF), .READ_CYC(RD)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .wp_n(wp_n), .preset(preset), .rdy(rdy), .wiper_a(wiper_a),
    .wiper_b(wiper_b), .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input int sel, input int data);
    cmd_word  = {op, 5'(sel), 5'b0, 10'(data)};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (!rdy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic put(input logic [3:0] op, input int sel, input int data);
    wait_rdy();
    send(op, sel, data);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 wiper_a", wiper_a, 512);
    chk("R1 wiper_b", wiper_b, 512);
    repeat (RF - 1) @(negedge clk);
    chk("R1 rdy low", rdy, 0);
    @(negedge clk);
    chk("R1 rdy high", rdy, 1);
    chk("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_write();
    put(11, 0, 341);
    chk("R2 load a", wiper_a, 341);
    chk("R6 no busy on load", rdy, 1);
    put(11, 1, 682);
    chk("R2 load b", wiper_b, 682);
    chk("R2 a untouched", wiper_a, 341);
  endtask

  task automatic t_linear();
    put(11, 0, 1022);
    put(14, 0, 0);  chk("R3 inc a", wiper_a, 1023);
    put(14, 0, 0);  chk("R3 inc ceiling", wiper_a, 1023);
    put(11, 1, 1);
    put(6, 1, 0);   chk("R3 dec b", wiper_b, 0);
    put(6, 1, 0);   chk("R3 dec floor", wiper_b, 0);
    put(15, 0, 0);  chk("R3 inc both a", wiper_a, 1023); chk("R3 inc both b", wiper_b, 1);
    put(7, 0, 0);   chk("R3 dec both a", wiper_a, 1022); chk("R3 dec both b", wiper_b, 0);
  endtask

  task automatic t_log();
    put(11, 0, 300);
    put(12, 0, 0);  chk("R4 double", wiper_a, 600);
    put(12, 0, 0);  chk("R4 double sat", wiper_a, 1023);
    put(11, 0, 512);
    put(12, 0, 0);  chk("R4 double 512", wiper_a, 1023);
    put(11, 1, 3);
    put(4, 1, 0);   chk("R4 halve 3", wiper_b, 1);
    put(4, 1, 0);   chk("R4 halve 1", wiper_b, 0);
    put(4, 1, 0);   chk("R4 halve 0", wiper_b, 0);
    put(11, 0, 37);
    put(13, 0, 0);  chk("R4 double both a", wiper_a, 74); chk("R4 double both b", wiper_b, 0);
    put(5, 0, 0);   chk("R4 halve both a", wiper_a, 37);
  endtask

  task automatic t_store();
    put(11, 0, 77);
    put(2, 0, 0);
    chk("R6 store busy", rdy, 0);
    repeat (ST - 1) @(negedge clk);
    chk("R6 store still busy", rdy, 0);
    @(negedge clk);
    chk("R6 store done", rdy, 1);
    put(11, 0, 5);
    put(1, 0, 0);
    chk("R5 restore one", wiper_a, 77);
    chk("R6 restore one no busy", rdy, 1);
    put(11, 1, 88);
    put(2, 1, 0);
    put(11, 0, 6);
    put(11, 1, 7);
    put(8, 0, 0);
    chk("R5 restore all a", wiper_a, 77);
    chk("R5 restore all b", wiper_b, 88);
    chk("R6 refresh busy", rdy, 0);
    repeat (RF - 1) @(negedge clk);
    chk("R6 refresh still busy", rdy, 0);
    @(negedge clk);
    chk("R6 refresh done", rdy, 1);
  endtask

  task automatic t_busy();
    put(2, 0, 0);
    send(11, 0, 999);
    chk("R7 err while busy", cmd_err, 1);
    chk("R7 wiper kept", wiper_a, 77);
    wait_rdy();
    chk("R7 wiper kept after", wiper_a, 77);
  endtask

  task automatic t_read();
    put(11, 1, 300);
    put(10, 1, 0);
    chk("R8 read busy", rdy, 0);
    chk("R8 no early valid", rd_valid, 0);
    repeat (RD - 1) @(negedge clk);
    chk("R8 read still busy", rdy, 0);
    @(negedge clk);
    chk("R8 valid at rise", rd_valid, 1);
    chk("R8 wiper data", rd_data, 300);
    @(negedge clk);
    chk("R8 valid one cycle", rd_valid, 0);
    put(9, 0, 0);
    repeat (RD) @(negedge clk);
    chk("R8 saved valid", rd_valid, 1);
    chk("R8 saved data", rd_data, 77);
  endtask

  task automatic t_user();
    put(3, 2, 'hA5);
    put(3, 27, 'h3C);
    put(9, 2, 0);
    repeat (RD) @(negedge clk);
    chk("R9 user byte 0", rd_data, 'hA5);
    put(9, 27, 0);
    repeat (RD) @(negedge clk);
    chk("R9 user byte 25", rd_data, 'h3C);
    put(3, 28, 1);
    chk("R9 out of range err", cmd_err, 1);
    chk("R9 out of range no busy", rdy, 1);
  endtask

  task automatic t_badsel();
    put(11, 5, 9);
    chk("R12 bad sel err", cmd_err, 1);
    chk("R12 a kept", wiper_a, 77);
    chk("R12 b kept", wiper_b, 300);
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    put(11, 0, 1);
    chk("R10 load err", cmd_err, 1);
    chk("R10 load blocked", wiper_a, 77);
    put(14, 1, 0);
    chk("R10 inc blocked", wiper_b, 300);
    put(2, 1, 0);
    chk("R10 store err", cmd_err, 1);
    chk("R10 store no busy", rdy, 1);
    put(9, 1, 0);
    repeat (RD) @(negedge clk);
    chk("R10 saved b unchanged", rd_data, 88);
    put(1, 1, 0);
    chk("R10 restore allowed", wiper_b, 88);
    chk("R10 restore no err", cmd_err, 0);
    wp_n = 1'b1;
  endtask

  task automatic t_preset();
    put(11, 0, 11);
    put(11, 1, 22);
    wait_rdy();
    preset = 1'b1;
    @(negedge clk);
    chk("R11 preset a", wiper_a, 77);
    chk("R11 preset b", wiper_b, 88);
    chk("R11 preset busy", rdy, 0);
    repeat (RF - 1) @(negedge clk);
    chk("R11 preset still busy", rdy, 0);
    @(negedge clk);
    chk("R11 preset done", rdy, 1);
    put(11, 0, 33);
    repeat (3) @(negedge clk);
    chk("R11 held level no reload", wiper_a, 33);
    chk("R11 held level no busy", rdy, 1);
    preset = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write();
    t_linear();
    t_log();
    t_store();
    t_busy();
    t_read();
    t_user();
    t_badsel();
    t_wp();
    t_preset();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule